// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor request port and a slower main-memory port. It serves byte reads and byte writes on byte addresses. Every set holds two lines of four bytes. Each line keeps a tag, a valid flag and a modified (dirty) flag, and each set keeps one bit that names its least recently used way. A hit completes in the cycle the request is presented. A miss picks a victim way and writes that line back to memory if it has been modified. The block then fetches the requested line, places it in the victim way and completes the access.

Two static configuration inputs control the policy. `writeThrough` switches stores from write-back to write-through. `cacheDisable` sends every access straight to memory as a single-byte transfer and leaves the cache contents untouched. The processor holds its request until `cpuReady` is high. The memory side uses a request/acknowledge handshake with one word (one line) per acknowledge.

With the default parameters the 24-bit address divides into a 9-bit tag, a 13-bit set index and a 2-bit byte offset.

Top module: `twoway_cache`

## Requirements
- R1: The byte address is decoded as tag = upper TAG_W bits, set index = next SET_W bits, and byte offset = bits [1:0]. Byte k of a line is carried on bits [8k+7:8k] of the memory data. Every memory transfer uses a word-aligned address (`memAddr[1:0]` = 0).
- R2: After reset no way is valid, so the first access to any address is a miss. With no request pending, `cpuReady` and `memReq` are low.
- R3: A hit happens when a valid way in the indexed set holds the address tag. At most one way can hit. A hit read, or a hit write in write-back mode, raises `cpuReady` in the same cycle the request is presented and makes no memory transfer.
- R4: On a miss the block reads the line from memory at the line address of the request. It stores the line and only then raises `cpuReady`, and a read returns the requested byte.
- R5: The fill way is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the least recently used way. Every hit and every fill marks the accessed way as most recently used.
- R6: In write-back mode (`writeThrough` = 0) a write hit updates only the cache and marks the line modified. Evicting a modified line first writes the whole line (`memBe` = 1111) to its old address. A clean line is evicted with no memory write.
- R7: In write-through mode (`writeThrough` = 1) every write makes one memory write. That write has `memBe` one-hot at the byte offset and the byte repeated on all four lanes, and the cached copy is updated as well.
- R8: A write miss allocates the line: the line is fetched first, then the written byte is merged into it.
- R9: With `cacheDisable` = 1 every access is a single memory transfer with a one-hot `memBe`. A read returns the memory byte. Cached lines, tags and flags are not changed, so after re-enabling, a line cached earlier still hits with its old contents.
- R10: While `memReq` is high and `memAck` is low, the memory address, direction and write data stay stable.
- R11: `cpuReady` is high only while `cpuReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cacheDisable | input | 1 | 1 = bypass the cache for all accesses |
| writeThrough | input | 1 | 1 = write-through, 0 = write-back |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = byte write, 0 = byte read |
| cpuAddr | input | TAG_W+SET_W+2 | Byte address |
| cpuWdata | input | 8 | Byte to write |
| cpuReady | output | 1 | Access completes in this cycle |
| cpuRdata | output | 8 | Read byte, valid with `cpuReady` |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | TAG_W+SET_W+2 | Word-aligned memory address |
| memBe | output | 4 | Byte lane enables for writes |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Transfer completes in this cycle |

## Verification
The hardest case to reach from the ports is the eviction of a modified line whose set is full. Reaching it needs two earlier fills in that set, a store to one of those lines, and a third tag that maps to the same set, with the LRU bit pointing at the modified way. The bench builds the block with 4 sets and a 7-bit address, so strided sweeps over all 128 byte addresses keep hitting full sets with mixed modified states. A bench-side model of tags, flags and LRU bits predicts for each access whether it hits, how many line writes, line reads and byte writes it causes, and whether it completes in the first cycle. A short directed sequence in one set pins down the LRU order, and every full-line write is compared against the latest bytes stored by the processor.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU,
    ST_BYPASS
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillLine;      // load memRdata into victim way, mark valid+clean
    logic writeByte;     // merge cpuWdata into hit way
    logic touch;         // mark hit way most recently used
    logic markDirty;     // set modified flag of hit way
    logic useVictimAddr; // memory side addresses the victim line
    logic useMemByte;    // read byte comes from memory (bypass)
  } ctlStrobe_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int TAG_W = 9,
  parameter int SET_W = 13,
  localparam int ADDR_W = TAG_W + SET_W + 2,
  localparam int NSETS = 1 << SET_W,
  localparam int NWAYS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  ctlStrobe_t        strb,
  input  logic [31:0]       memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [7:0]        cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata
);

  logic [TAG_W-1:0] addrTag;
  logic [SET_W-1:0] setIdx;
  logic [1:0]       offIdx;

  assign addrTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign setIdx  = cpuAddr[SET_W+1:2];
  assign offIdx  = cpuAddr[1:0];

  logic [31:0]      lineData [NWAYS][NSETS];
  logic [TAG_W-1:0] tagMem   [NWAYS][NSETS];
  logic [NSETS-1:0] validBits [NWAYS];
  logic [NSETS-1:0] dirtyBits [NWAYS];
  logic [NSETS-1:0] lruBits;   // names the least recently used way

  logic [NWAYS-1:0] hitVec;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign hitVec[w] = validBits[w][setIdx] && (tagMem[w][setIdx] == addrTag);
  end

  logic hitWay;
  logic victimWay;

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  always_comb begin
    if (!validBits[0][setIdx])      victimWay = 1'b0;
    else if (!validBits[1][setIdx]) victimWay = 1'b1;
    else                            victimWay = lruBits[setIdx];
  end

  assign victimDirty = validBits[victimWay][setIdx] && dirtyBits[victimWay][setIdx];

  logic [31:0]       hitLine;
  logic [31:0]       victimLine;
  logic [ADDR_W-1:0] victimAddr;
  logic [3:0]        laneOneHot;

  assign hitLine    = lineData[hitWay][setIdx];
  assign victimLine = lineData[victimWay][setIdx];
  assign victimAddr = {tagMem[victimWay][setIdx], setIdx, 2'b00};
  assign laneOneHot = 4'b0001 << offIdx;

  assign memAddr  = strb.useVictimAddr ? victimAddr : {cpuAddr[ADDR_W-1:2], 2'b00};
  assign memWdata = strb.useVictimAddr ? victimLine : {4{cpuWdata}};
  assign memBe    = strb.useVictimAddr ? 4'hF : laneOneHot;
  assign cpuRdata = strb.useMemByte ? memRdata[{offIdx, 3'b000} +: 8]
                                    : hitLine[{offIdx, 3'b000} +: 8];

  // line storage: no reset needed, valid flags guard it
  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      lineData[victimWay][setIdx] <= memRdata;
      tagMem[victimWay][setIdx]   <= addrTag;
    end else if (strb.writeByte) begin
      lineData[hitWay][setIdx][{offIdx, 3'b000} +: 8] <= cpuWdata;
    end
  end

  // per-line and per-set flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NWAYS; w++) begin
        validBits[w] <= '0;
        dirtyBits[w] <= '0;
      end
      lruBits <= '0;
    end else begin
      if (strb.fillLine) begin
        validBits[victimWay][setIdx] <= 1'b1;
        dirtyBits[victimWay][setIdx] <= 1'b0;
        lruBits[setIdx]              <= ~victimWay;
      end
      if (strb.touch) begin
        lruBits[setIdx] <= ~hitWay;
      end
      if (strb.markDirty) begin
        dirtyBits[hitWay][setIdx] <= 1'b1;
      end
    end
  end

  // R3: two ways of a set never hold the same tag
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R4: a fill is only commanded when the lookup misses
  assert_fill_on_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |-> !hit);

  // R8: a fill is followed by a hit on the same request
  assert_fill_then_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> hit);

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cacheDisable,
  input  logic       writeThrough,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memAck,
  output ctlStrobe_t strb,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cacheDisable) begin
            stateNext = ST_BYPASS;
          end else if (hit) begin
            if (cpuWe && writeThrough) begin
              stateNext = ST_WTHRU;
            end else begin
              cpuReady       = 1'b1;
              strb.touch     = 1'b1;
              strb.writeByte = cpuWe;
              strb.markDirty = cpuWe;
            end
          end else if (victimDirty) begin
            stateNext = ST_WBACK;
          end else begin
            stateNext = ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        memReq             = 1'b1;
        memWe              = 1'b1;
        strb.useVictimAddr = 1'b1;
        if (memAck) stateNext = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.fillLine = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuReady       = 1'b1;
          strb.touch     = 1'b1;
          strb.writeByte = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      ST_BYPASS: begin
        memReq          = 1'b1;
        memWe           = cpuWe;
        strb.useMemByte = 1'b1;
        if (memAck) begin
          cpuReady  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R11: completion only for a live request
  assert_ready_has_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  // R10: a pending transfer keeps its direction until acknowledged
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R6: a line write-back is only issued for a modified victim
  assert_wb_only_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WBACK) |-> victimDirty);

  // R9: with the cache disabled nothing completes without memory
  assert_bypass_waits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cpuReq && cacheDisable) |-> (!cpuReady && !strb.touch));

endmodule

// File: rtl/twoway_cache.sv
module twoway_cache
  import cache_pkg::*;
#(
  parameter int TAG_W = 9,
  parameter int SET_W = 13,
  localparam int ADDR_W = TAG_W + SET_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheDisable,
  input  logic              writeThrough,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic              cpuReady,
  output logic [7:0]        cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);

  ctlStrobe_t strb;
  logic       hit;
  logic       victimDirty;

  cache_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cacheDisable (cacheDisable),
    .writeThrough (writeThrough),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .hit          (hit),
    .victimDirty  (victimDirty),
    .memAck       (memAck),
    .strb         (strb),
    .cpuReady     (cpuReady),
    .memReq       (memReq),
    .memWe        (memWe)
  );

  cache_datapath #(
    .TAG_W (TAG_W),
    .SET_W (SET_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .strb        (strb),
    .memRdata    (memRdata),
    .hit         (hit),
    .victimDirty (victimDirty),
    .cpuRdata    (cpuRdata),
    .memAddr     (memAddr),
    .memBe       (memBe),
    .memWdata    (memWdata)
  );

  // R1: every memory transfer is word aligned
  assert_mem_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

endmodule

// File: tb/sim_twoway_cache.sv
module sim_twoway_cache;

  localparam int TAG_W  = 3;
  localparam int SET_W  = 2;
  localparam int ADDR_W = TAG_W + SET_W + 2;
  localparam int NBYTES = 1 << ADDR_W;
  localparam int NSETS  = 1 << SET_W;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cacheDisable = 1'b0;
  logic writeThrough = 1'b0;
  logic cpuReq = 1'b0;
  logic cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic cpuReady;
  logic [7:0] cpuRdata;
  logic memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;

  always #5 clk = ~clk;

  twoway_cache #(.TAG_W(TAG_W), .SET_W(SET_W)) u0 (
    .clk(clk), .rstN(rstN), .cacheDisable(cacheDisable), .writeThrough(writeThrough),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model and shadow of the latest stored bytes
  logic [7:0] memArr [NBYTES];
  logic [7:0] golden [NBYTES];
  bit goldenLive = 1'b1;
  int rdCnt = 0, lineWrCnt = 0, byteWrCnt = 0;
  int latCnt = 0;
  logic [ADDR_W-1:0] startAddr = '0;

  always @(posedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
      latCnt = 0;
    end else if (memReq) begin
      if (latCnt == 0) startAddr = memAddr;
      if (latCnt == LAT) begin
        memAck <= 1'b1;
        chk(memAddr[1:0] == 2'b00, "R1 aligned", int'(memAddr[1:0]), 0);
        chk(memAddr == startAddr, "R10 addr stable", int'(memAddr), int'(startAddr));
        if (memWe) begin
          if (memBe == 4'hF) begin
            lineWrCnt++;
            if (goldenLive)
              for (int k = 0; k < 4; k++)
                chk(memWdata[8*k +: 8] == golden[memAddr + k], "R6 writeback data",
                    int'(memWdata[8*k +: 8]), int'(golden[memAddr + k]));
          end else begin
            byteWrCnt++;
          end
          for (int k = 0; k < 4; k++)
            if (memBe[k]) memArr[memAddr + k] = memWdata[8*k +: 8];
        end else begin
          rdCnt++;
          memRdata <= {memArr[memAddr + 3], memArr[memAddr + 2],
                       memArr[memAddr + 1], memArr[memAddr]};
        end
      end else begin
        latCnt++;
      end
    end
  end

  // bench model of the cache state
  bit       refValid [2][NSETS];
  bit       refDirty [2][NSETS];
  int       refTag   [2][NSETS];
  bit       refLru   [NSETS];

  int gotRd;
  bit gotFast;

  task automatic run_access(input bit we, input int addr, input logic [7:0] data,
                            output bit timedOut);
    int cyc = 0;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = ADDR_W'(addr); cpuWdata = data;
    #1;
    timedOut = 1'b0;
    while (!cpuReady) begin
      @(negedge clk); #1;
      cyc++;
      if (cyc > 100) begin timedOut = 1'b1; break; end
    end
    gotRd = int'(cpuRdata);
    gotFast = (cyc == 0);
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic cached_access(input bit we, input int addr, input logic [7:0] data,
                               input string tag);
    int s = (addr >> 2) % NSETS;
    int t = addr >> (SET_W + 2);
    int h = -1, way, expRd, expLn, expBy, expData;
    bit expFast, tmo;
    int rd0 = rdCnt, ln0 = lineWrCnt, by0 = byteWrCnt;
    for (int w = 0; w < 2; w++) if (refValid[w][s] && refTag[w][s] == t) h = w;
    if (h >= 0) begin
      expRd = 0; expLn = 0; way = h;
    end else begin
      way = !refValid[0][s] ? 0 : (!refValid[1][s] ? 1 : int'(refLru[s]));
      expLn = (refValid[way][s] && refDirty[way][s]) ? 1 : 0;
      expRd = 1;
      refValid[way][s] = 1'b1; refTag[way][s] = t; refDirty[way][s] = 1'b0;
    end
    expBy = (we && writeThrough) ? 1 : 0;
    expFast = (h >= 0) && !(we && writeThrough);
    refLru[s] = (way == 0);
    if (we && !writeThrough) refDirty[way][s] = 1'b1;
    expData = int'(golden[addr]);
    if (we) golden[addr] = data;
    run_access(we, addr, data, tmo);
    chk(!tmo, {tag, " completion"}, int'(tmo), 0);
    chk(gotFast == expFast, {tag, " single-cycle hit"}, int'(gotFast), int'(expFast));
    chk(rdCnt - rd0 == expRd, {tag, " line reads"}, rdCnt - rd0, expRd);
    chk(lineWrCnt - ln0 == expLn, {tag, " R6 line writebacks"}, lineWrCnt - ln0, expLn);
    chk(byteWrCnt - by0 == expBy, {tag, " R7 byte writes"}, byteWrCnt - by0, expBy);
    if (!we) chk(gotRd == expData, {tag, " read data"}, gotRd, expData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rd0, by0, ln0, a, oldVal;
    bit tmo;
    for (int i = 0; i < NBYTES; i++) begin
      memArr[i] = 8'(i ^ 8'h5A);
      golden[i] = 8'(i ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(cpuReady == 1'b0, "R2 ready low after reset", int'(cpuReady), 0);
    chk(memReq == 1'b0, "R2 memReq low after reset", int'(memReq), 0);
    chk(cpuReady == 1'b0, "R11 no ready without request", int'(cpuReady), 0);
    @(negedge clk);

    // first access is a miss after reset
    cached_access(1'b0, 9, 8'h00, "R2");

    // directed LRU order in set 1: tags 1,2 fill, touch 1, tag 3 evicts 2
    cached_access(1'b0, (1 << 4) | 4, 8'h00, "R5");
    cached_access(1'b0, (2 << 4) | 4, 8'h00, "R5");
    cached_access(1'b0, (1 << 4) | 5, 8'h00, "R5");
    cached_access(1'b0, (3 << 4) | 6, 8'h00, "R5");
    cached_access(1'b0, (1 << 4) | 7, 8'h00, "R5");
    cached_access(1'b0, (2 << 4) | 4, 8'h00, "R5");

    // write-back mode sweeps
    writeThrough = 1'b0;
    for (int i = 0; i < NBYTES; i++)
      cached_access(1'b1, (i * 5) % NBYTES, 8'(i * 7 + 3), "R8");
    for (int i = 0; i < NBYTES; i++)
      cached_access(1'b0, (i * 3 + 1) % NBYTES, 8'h00, "R4");
    for (int i = 0; i < 96; i++)
      cached_access(i % 3 == 0, ((i % 5) << 4) | ((i % 2) << 2) | (i % 4), 8'(i + 100), "R6");

    // write-through mode sweeps
    writeThrough = 1'b1;
    for (int i = 0; i < NBYTES; i++)
      cached_access(i % 2 == 0, (i * 11 + 2) % NBYTES, 8'(i ^ 8'hC3), "R7");
    for (int i = 0; i < NBYTES; i++)
      cached_access(1'b0, i, 8'h00, "R3");

    // cache disabled: single transfers, cache left untouched
    a = 20;
    cached_access(1'b0, a, 8'h00, "R3");
    oldVal = gotRd;
    goldenLive = 1'b0;
    cacheDisable = 1'b1;
    rd0 = rdCnt; by0 = byteWrCnt; ln0 = lineWrCnt;
    run_access(1'b0, a, 8'h00, tmo);
    chk(gotRd == int'(memArr[a]), "R9 bypass read data", gotRd, int'(memArr[a]));
    chk(rdCnt - rd0 == 1, "R9 bypass read count", rdCnt - rd0, 1);
    run_access(1'b1, a, 8'(oldVal ^ 8'hFF), tmo);
    chk(byteWrCnt - by0 == 1, "R9 bypass byte write", byteWrCnt - by0, 1);
    chk(int'(memArr[a]) == (oldVal ^ 8'hFF), "R9 memory updated", int'(memArr[a]), oldVal ^ 8'hFF);
    chk(lineWrCnt == ln0, "R9 no line write", lineWrCnt - ln0, 0);
    cacheDisable = 1'b0;
    rd0 = rdCnt;
    run_access(1'b0, a, 8'h00, tmo);
    chk(gotRd == oldVal, "R9 cached copy untouched", gotRd, oldVal);
    chk(gotFast == 1'b1, "R9 still a hit", int'(gotFast), 1);
    chk(rdCnt == rd0, "R9 no fetch after re-enable", rdCnt - rd0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule